// File: doc/BRIEF.md
# Host/Controller Mailbox and Doorbell Register File

This block is the shared register window between a host and a service controller. It holds eight 64-bit words that the host reaches over a simple register bus. Four of them carry a command from the host and four carry a response back. Two doorbell registers, one for each direction, signal that a message is ready. Each doorbell can be written three ways: by plain replacement, by an AND merge with its current contents, or by an OR merge with them. Each doorbell keeps only its own set of defined bits.

Setting the inbound "message waiting" bit does not leave a persistent flag. The bit clears at once, and the block pulses a one-cycle strobe to the command processor, which then reads the four command words from a flat output. The command processor raises bits in the outbound doorbell through a dedicated set-bits port. The host sees a level interrupt for as long as any outbound doorbell bit is set.

Bit numbering in the doorbells is MSB-first: doorbell bit n is bit 63-n of the 64-bit data word. Reads are combinational from the current register state. Writes take effect at the rising clock edge.

Top module: `mbox_bell_regfile`

## Requirements
- R1: After reset all eight words and both doorbells read zero, `hostIrq` is low and `cmdStrobe` is low.
- R2: Word offsets 0x00 to 0x07 are plain 64-bit read/write storage. A write changes only the addressed word.
- R3: The inbound doorbell is written at 0x10 (replace), 0x11 (AND with the stored value) and 0x12 (OR with the stored value). Only doorbell bit 0 (data bit 63) is kept, and it self-clears, so a read of 0x10 returns zero after any write.
- R4: `cmdStrobe` is high for exactly the one cycle after an inbound doorbell write whose merged result has data bit 63 set. An AND-merge write or a write with data bit 63 clear produces no strobe.
- R5: The outbound doorbell is written at 0x13 (replace), 0x14 (AND with the stored value) and 0x15 (OR with the stored value). A read of 0x13 returns the stored value.
- R6: The outbound doorbell keeps only doorbell bits 0 to 4 and bit 14, which is data mask 0xF802_0000_0000_0000. All other bits are dropped on every kind of write.
- R7: `hostIrq` is high exactly when the stored outbound doorbell is nonzero.
- R8: Bits on `cpSet`, restricted to the R6 mask, are ORed into the outbound doorbell at the same edge. When a bus write to the outbound doorbell occurs in the same cycle, the bus result is formed first and the `cpSet` bits are ORed on top. Bits of `cpSet` outside the mask have no effect.
- R9: Reads of offsets other than 0x00 to 0x07, 0x10 and 0x13 return zero, including the merge aliases 0x11, 0x12, 0x14 and 0x15. Writes to unmapped offsets change no stored state.
- R10: `cmdBlock` presents command word k (offset k, k = 0 to 3) on bits [64k+63:64k].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 6 | Word offset of the access |
| busWrEn | input | 1 | Write strobe for the current cycle |
| busWrData | input | 64 | Write data |
| busRdData | output | 64 | Read data for `busAddr`, combinational |
| cpSet | input | 64 | Command processor set-bits request for the outbound doorbell |
| hostIrq | output | 1 | Level interrupt toward the host |
| cmdStrobe | output | 1 | One-cycle command-ready pulse |
| cmdBlock | output | 256 | Command words 0 to 3, concatenated |

## Verification
The assertions assume that `busWrEn`, `busAddr` and `cpSet` are driven to known values in every cycle and are held at zero or idle while reset is asserted. They also assume that an access lasts exactly one cycle, so a request is never in flight across the release of reset. The bench changes every input only on the falling edge and keeps all inputs at zero throughout reset. It raises `busWrEn` for a single cycle per write, and presents `cpSet` for a single cycle, alone or together with a bus write.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

  localparam int DATA_W    = 64;
  localparam int CMD_WORDS = 4;
  localparam int RSP_WORDS = 4;
  localparam int ALL_WORDS = CMD_WORDS + RSP_WORDS;
  localparam int IDX_W     = $clog2(ALL_WORDS);

  // How a write combines with the stored doorbell value
  typedef enum logic [1:0] {
    MRG_SET = 2'd0,
    MRG_AND = 2'd1,
    MRG_OR  = 2'd2
  } mergeOp_t;

  typedef enum logic [1:0] {
    RD_NONE = 2'd0,
    RD_WORD = 2'd1,
    RD_IN   = 2'd2,
    RD_OUT  = 2'd3
  } rdKind_t;

  // Strobes from the decoder to the storage datapath
  typedef struct packed {
    logic             wrWord;
    logic [IDX_W-1:0] wordIdx;
    logic             wrIn;
    logic             wrOut;
    mergeOp_t         op;
    rdKind_t          rdKind;
  } mboxCtrl_t;

endpackage

// File: rtl/mbox_decode.sv
module mbox_decode
  import mbox_pkg::*;
#(
  parameter int               ADDR_W   = 6,
  parameter logic [ADDR_W-1:0] IN_BASE  = 6'h10,
  parameter logic [ADDR_W-1:0] OUT_BASE = 6'h13
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  output mboxCtrl_t         ctrl
);

  localparam logic [ADDR_W-1:0] WORD_LIMIT = ADDR_W'(ALL_WORDS);
  localparam logic [ADDR_W-1:0] ALIAS_SPAN = ADDR_W'(3);

  logic              hitWord;
  logic              hitIn;
  logic              hitOut;
  logic [ADDR_W-1:0] inOff;
  logic [ADDR_W-1:0] outOff;

  always_comb begin
    inOff   = busAddr - IN_BASE;
    outOff  = busAddr - OUT_BASE;
    hitWord = busAddr < WORD_LIMIT;
    hitIn   = (busAddr >= IN_BASE) && (inOff < ALIAS_SPAN);
    hitOut  = (busAddr >= OUT_BASE) && (outOff < ALIAS_SPAN);
  end

  always_comb begin
    ctrl         = '0;
    ctrl.wordIdx = busAddr[IDX_W-1:0];
    ctrl.wrWord  = busWrEn && hitWord;
    ctrl.wrIn    = busWrEn && hitIn;
    ctrl.wrOut   = busWrEn && hitOut;
    ctrl.op      = MRG_SET;
    if (hitIn) begin
      ctrl.op = mergeOp_t'(inOff[1:0]);
    end else if (hitOut) begin
      ctrl.op = mergeOp_t'(outOff[1:0]);
    end
    if (hitWord) begin
      ctrl.rdKind = RD_WORD;
    end else if (busAddr == IN_BASE) begin
      ctrl.rdKind = RD_IN;
    end else if (busAddr == OUT_BASE) begin
      ctrl.rdKind = RD_OUT;
    end else begin
      ctrl.rdKind = RD_NONE;
    end
  end

  // R9
  one_target_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ctrl.wrWord, ctrl.wrIn, ctrl.wrOut}));

endmodule

// File: rtl/mbox_store.sv
module mbox_store
  import mbox_pkg::*;
#(
  parameter logic [DATA_W-1:0] IN_KEEP  = 64'h8000_0000_0000_0000,
  parameter logic [DATA_W-1:0] OUT_KEEP = 64'hF802_0000_0000_0000
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  mboxCtrl_t                   ctrl,
  input  logic [DATA_W-1:0]           wrData,
  input  logic [DATA_W-1:0]           cpSet,
  output logic [DATA_W-1:0]           rdData,
  output logic [CMD_WORDS*DATA_W-1:0] cmdBlock,
  output logic                        hostIrq,
  output logic                        cmdStrobe
);

  // Doorbell bit 0 in MSB-first numbering
  localparam logic [DATA_W-1:0] MSG_BIT = {1'b1, {(DATA_W-1){1'b0}}};

  logic [ALL_WORDS-1:0][DATA_W-1:0] wordQ;
  logic [DATA_W-1:0] inBellQ;
  logic [DATA_W-1:0] outBellQ;
  logic [DATA_W-1:0] inMerged;
  logic [DATA_W-1:0] outBase;
  logic [DATA_W-1:0] cpBits;
  logic              fire;

  function automatic logic [DATA_W-1:0] mergeBell(mergeOp_t op,
                                                  logic [DATA_W-1:0] cur,
                                                  logic [DATA_W-1:0] val);
    case (op)
      MRG_AND: mergeBell = cur & val;
      MRG_OR:  mergeBell = cur | val;
      default: mergeBell = val;
    endcase
  endfunction

  for (genvar i = 0; i < ALL_WORDS; i++) begin : g_word
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        wordQ[i] <= '0;
      end else if (ctrl.wrWord && ctrl.wordIdx == IDX_W'(i)) begin
        wordQ[i] <= wrData;
      end
    end
  end

  for (genvar k = 0; k < CMD_WORDS; k++) begin : g_cmd
    assign cmdBlock[k*DATA_W +: DATA_W] = wordQ[k];
  end

  always_comb begin
    inMerged = mergeBell(ctrl.op, inBellQ, wrData) & IN_KEEP;
    fire     = ctrl.wrIn && ((inMerged & MSG_BIT) != '0);
    cpBits   = cpSet & OUT_KEEP;
    outBase  = ctrl.wrOut ? (mergeBell(ctrl.op, outBellQ, wrData) & OUT_KEEP)
                          : outBellQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inBellQ   <= '0;
      outBellQ  <= '0;
      cmdStrobe <= 1'b0;
    end else begin
      if (ctrl.wrIn) begin
        inBellQ <= inMerged & ~MSG_BIT;
      end
      outBellQ  <= outBase | cpBits;
      cmdStrobe <= fire;
    end
  end

  assign hostIrq = |outBellQ;

  always_comb begin
    case (ctrl.rdKind)
      RD_WORD: rdData = wordQ[ctrl.wordIdx];
      RD_IN:   rdData = inBellQ;
      RD_OUT:  rdData = outBellQ;
      default: rdData = '0;
    endcase
  end

  // R4
  strobe_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmdStrobe |-> $past(ctrl.wrIn && ctrl.op != MRG_AND && wrData[DATA_W-1]));

  // R2
  word_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ctrl.wrWord |=> $stable(wordQ));

  // R5
  out_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!ctrl.wrOut && cpSet == '0) |=> $stable(outBellQ));

  // R7
  irq_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(hostIrq) |-> $past(ctrl.wrOut || (cpSet & OUT_KEEP) != '0));

  // R8
  cp_stick_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cpSet & OUT_KEEP) != '0 |=>
      (outBellQ & $past(cpSet & OUT_KEEP)) == $past(cpSet & OUT_KEEP));

endmodule

// File: rtl/mbox_bell_regfile.sv
module mbox_bell_regfile
  import mbox_pkg::*;
#(
  parameter int                ADDR_W   = 6,
  parameter logic [ADDR_W-1:0] IN_BASE  = 6'h10,
  parameter logic [ADDR_W-1:0] OUT_BASE = 6'h13,
  parameter logic [63:0]       IN_KEEP  = 64'h8000_0000_0000_0000,
  parameter logic [63:0]       OUT_KEEP = 64'hF802_0000_0000_0000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [63:0]       busWrData,
  output logic [63:0]       busRdData,
  input  logic [63:0]       cpSet,
  output logic              hostIrq,
  output logic              cmdStrobe,
  output logic [255:0]      cmdBlock
);

  mboxCtrl_t ctrl;

  mbox_decode #(
    .ADDR_W  (ADDR_W),
    .IN_BASE (IN_BASE),
    .OUT_BASE(OUT_BASE)
  ) u_decode (
    .clk    (clk),
    .rstN   (rstN),
    .busAddr(busAddr),
    .busWrEn(busWrEn),
    .ctrl   (ctrl)
  );

  mbox_store #(
    .IN_KEEP (IN_KEEP),
    .OUT_KEEP(OUT_KEEP)
  ) u_store (
    .clk      (clk),
    .rstN     (rstN),
    .ctrl     (ctrl),
    .wrData   (busWrData),
    .cpSet    (cpSet),
    .rdData   (busRdData),
    .cmdBlock (cmdBlock),
    .hostIrq  (hostIrq),
    .cmdStrobe(cmdStrobe)
  );

endmodule

// File: tb/test_mbox_bell_regfile.sv
module test_mbox_bell_regfile;

  localparam int CLK_P = 10;
  localparam logic [63:0] ONES = 64'hFFFF_FFFF_FFFF_FFFF;
  localparam logic [63:0] OMSK = 64'hF802_0000_0000_0000;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [5:0]   busAddr = '0;
  logic         busWrEn = 1'b0;
  logic [63:0]  busWrData = '0;
  logic [63:0]  busRdData;
  logic [63:0]  cpSet = '0;
  logic         hostIrq;
  logic         cmdStrobe;
  logic [255:0] cmdBlock;

  mbox_bell_regfile i_mbox_bell_regfile (
    .clk      (clk),
    .rstN     (rstN),
    .busAddr  (busAddr),
    .busWrEn  (busWrEn),
    .busWrData(busWrData),
    .busRdData(busRdData),
    .cpSet    (cpSet),
    .hostIrq  (hostIrq),
    .cmdStrobe(cmdStrobe),
    .cmdBlock (cmdBlock)
  );

  always #(CLK_P/2) clk = ~clk;

  typedef struct {
    int          kind;   // 0 read data, 1 irq, 2 strobe, 3 command word
    int          idx;
    logic [63:0] exp;
    string       tag;
  } item_t;

  item_t sbq[$];
  int total = 0;
  int bad = 0;
  bit finished = 0;

  // Monitor: compares queued expectations a quarter period after each falling edge
  initial begin
    forever begin
      @(negedge clk);
      #(CLK_P/4);
      while (sbq.size() > 0) begin
        item_t it;
        logic [63:0] act;
        it = sbq.pop_front();
        case (it.kind)
          0: act = busRdData;
          1: act = {63'd0, hostIrq};
          2: act = {63'd0, cmdStrobe};
          default: act = cmdBlock[it.idx*64 +: 64];
        endcase
        total++;
        if (act !== it.exp) begin
          bad++;
          $display("FAIL %s: actual=%h expected=%h", it.tag, act, it.exp);
        end
      end
    end
  end

  task automatic pushItem(int kind, int idx, logic [63:0] exp, string tag);
    item_t it;
    it.kind = kind; it.idx = idx; it.exp = exp; it.tag = tag;
    sbq.push_back(it);
  endtask

  // All tasks start and end at a falling edge
  task automatic busWrite(logic [5:0] a, logic [63:0] d, logic [63:0] cp);
    busAddr = a; busWrData = d; busWrEn = 1'b1; cpSet = cp;
    @(negedge clk);
    busWrEn = 1'b0; cpSet = '0; busWrData = '0;
  endtask

  task automatic cpOnly(logic [63:0] cp);
    cpSet = cp;
    @(negedge clk);
    cpSet = '0;
  endtask

  task automatic chkRd(logic [5:0] a, logic [63:0] exp, string tag);
    busAddr = a;
    pushItem(0, 0, exp, tag);
    @(negedge clk);
  endtask

  // Observes irq and strobe in the current cycle without advancing
  task automatic chkNow(logic irqExp, logic stbExp, string tag);
    pushItem(1, 0, {63'd0, irqExp}, {tag, " irq"});
    pushItem(2, 0, {63'd0, stbExp}, {tag, " strobe"});
  endtask

  task automatic chkCmd(int k, logic [63:0] exp, string tag);
    pushItem(3, k, exp, tag);
    @(negedge clk);
  endtask

  function automatic logic [63:0] pat(int i);
    return {32'hA5C3_0000 | 32'(i), 32'h1234_5678 ^ 32'(i * 32'h0101_0101)};
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    chkNow(1'b0, 1'b0, "R1 reset");
    for (int i = 0; i < 8; i++) chkRd(6'(i), 64'd0, "R1 word reset");
    chkRd(6'h10, 64'd0, "R1 inbound reset");
    chkRd(6'h13, 64'd0, "R1 outbound reset");

    // R2 storage
    for (int i = 0; i < 8; i++) busWrite(6'(i), pat(i), 64'd0);
    for (int i = 0; i < 8; i++) chkRd(6'(i), pat(i), "R2 word readback");
    busWrite(6'h05, ONES, 64'd0);
    chkRd(6'h05, ONES, "R2 single word");
    chkRd(6'h04, pat(4), "R2 neighbour low");
    chkRd(6'h06, pat(6), "R2 neighbour high");

    // R10 command block
    for (int k = 0; k < 4; k++) chkCmd(k, pat(k), "R10 cmdBlock word");

    // R3 / R4 inbound doorbell
    busWrite(6'h10, ONES, 64'd0);
    chkNow(1'b0, 1'b1, "R4 direct fires");
    chkRd(6'h10, 64'd0, "R3 self-clear");
    chkNow(1'b0, 1'b0, "R4 single pulse");
    busWrite(6'h10, 64'h7FFF_FFFF_FFFF_FFFF, 64'd0);
    chkNow(1'b0, 1'b0, "R4 bit clear no fire");
    chkRd(6'h10, 64'd0, "R3 other bits dropped");
    busWrite(6'h11, ONES, 64'd0);
    chkNow(1'b0, 1'b0, "R4 and-merge no fire");
    busWrite(6'h12, 64'h8000_0000_0000_0000, 64'd0);
    chkNow(1'b0, 1'b1, "R4 or-merge fires");
    chkRd(6'h10, 64'd0, "R3 after or-merge");

    // R5 / R6 / R7 outbound doorbell
    busWrite(6'h13, ONES, 64'd0);
    chkNow(1'b1, 1'b0, "R7 irq set");
    chkRd(6'h13, OMSK, "R6 direct masked");
    busWrite(6'h14, 64'h0800_0000_0000_0000, 64'd0);
    chkRd(6'h13, 64'h0800_0000_0000_0000, "R5 and-merge");
    busWrite(6'h15, 64'h0002_0000_0000_0001, 64'd0);
    chkRd(6'h13, 64'h0802_0000_0000_0000, "R5 or-merge masked");
    busWrite(6'h14, 64'd0, 64'd0);
    chkNow(1'b0, 1'b0, "R7 irq clear");
    chkRd(6'h13, 64'd0, "R5 and-merge to zero");
    busWrite(6'h13, 64'h07FD_FFFF_FFFF_FFFF, 64'd0);
    chkNow(1'b0, 1'b0, "R6 undefined bits no irq");
    chkRd(6'h13, 64'd0, "R6 undefined bits dropped");

    // R8 processor set port
    busWrite(6'h13, 64'h8000_0000_0000_0000, 64'h4000_0000_0000_0000);
    chkRd(6'h13, 64'hC000_0000_0000_0000, "R8 bus then set");
    cpOnly(64'h0002_0000_0000_0000);
    chkRd(6'h13, 64'hC002_0000_0000_0000, "R8 set alone");
    busWrite(6'h14, 64'd0, 64'h1000_0000_0000_0000);
    chkRd(6'h13, 64'h1000_0000_0000_0000, "R8 set over and-clear");
    cpOnly(64'h0000_0000_0000_0001);
    chkRd(6'h13, 64'h1000_0000_0000_0000, "R8 unmasked set ignored");
    chkNow(1'b1, 1'b0, "R7 irq from set");

    // R9 unmapped
    busWrite(6'h08, ONES, 64'd0);
    busWrite(6'h16, ONES, 64'd0);
    busWrite(6'h3F, ONES, 64'd0);
    chkNow(1'b1, 1'b0, "R9 unmapped write no strobe");
    chkRd(6'h08, 64'd0, "R9 read 0x08");
    chkRd(6'h3F, 64'd0, "R9 read 0x3F");
    chkRd(6'h11, 64'd0, "R9 alias 0x11");
    chkRd(6'h12, 64'd0, "R9 alias 0x12");
    chkRd(6'h14, 64'd0, "R9 alias 0x14");
    chkRd(6'h15, 64'd0, "R9 alias 0x15");
    chkRd(6'h00, pat(0), "R9 word0 untouched");
    chkRd(6'h07, pat(7), "R9 word7 untouched");
    chkRd(6'h13, 64'h1000_0000_0000_0000, "R9 outbound untouched");

    @(negedge clk);
    @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(CLK_P * 20000);
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule